// File: doc/BRIEF.md
# ALU Status and Reset-Cause Register

This block is the 8-bit status word of a small 8-bit microcontroller core. It stores the carry, auxiliary-carry and zero flags that the ALU produces, two read-only cause bits that tell software why the core last started or woke, and three writable page-select bits. The ALU supplies raw carry, half-carry or borrow bits and the result byte. The block turns these into stored flags. For subtract and compare it stores the inverse of the borrow.

The CPU reads the whole word and writes every bit except the two cause bits. Strobes from the sleep instruction, the watchdog-clear instruction, a watchdog time-out and an external reset move the cause bits. An interrupt entry saves the word into a shadow copy, and the interrupt return restores the writable bits from that copy. The stored carry is also brought out so that the datapath can feed it into a rotate.

Top module: `alu_status_reg`

Bit layout, MSB to LSB: [7:6] register-page select, [5] I/O-page select, [4] T (time-out), [3] P (power-down), [2] Z, [1] DC, [0] C. The ALU operation codes are add = 0, subtract = 1, compare = 2 and rotate = 3.

## Requirements
- R1: After a power-up reset (`rst_n` low at a clock edge) the word reads 0x18: T=1, P=1 and every other bit 0.
- R2: A CPU write loads bits 7:5 and 2:0 from the write data. T and P keep their values whatever the write data holds.
- R3: An add update (op 0) sets C to the carry-out input, sets DC to the bit-3 carry input, and sets Z to 1 only when the result is zero.
- R4: A subtract or compare update (op 1 or 2) sets C to the inverse of the borrow input and DC to the inverse of the low-nibble borrow input. Z follows the result as in R3.
- R5: A rotate update (op 3) sets C to the shifted-out bit and leaves Z and DC unchanged. `carry_o` always shows the stored C, which is the bit that enters the vacated position.
- R6: A sleep strobe sets T to 1 and clears P to 0.
- R7: A watchdog time-out clears T to 0 and leaves P unchanged. When it falls in the same cycle as another event, the time-out decides T.
- R8: A watchdog-clear strobe sets both T and P to 1.
- R9: An external reset strobe clears bits 7:5 and 2:0 and leaves T and P unchanged.
- R10: When a CPU write and an ALU update fall in the same cycle, the CPU write decides bits 7:5 and 2:0.
- R11: A save strobe copies the word into the shadow. A restore strobe reloads bits 7:5 and 2:0 from the shadow, takes priority over a CPU write in the same cycle, and leaves T and P untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| wr_en_i | input | 1 | CPU write strobe |
| wr_data_i | input | 8 | CPU write data |
| rd_data_o | output | 8 | Current status word |
| alu_vld_i | input | 1 | ALU flag-update strobe |
| alu_op_i | input | 2 | Operation: 0 add, 1 subtract, 2 compare, 3 rotate |
| alu_res_i | input | 8 | ALU result byte |
| alu_cy_i | input | 1 | Carry-out (add), borrow (sub/cmp) or shifted-out bit (rotate) |
| alu_hc_i | input | 1 | Bit-3 carry (add) or low-nibble borrow (sub/cmp) |
| carry_o | output | 1 | Stored carry, fed into rotates |
| sleep_i | input | 1 | Sleep instruction strobe |
| wdt_clr_i | input | 1 | Watchdog-clear instruction strobe |
| wdt_to_i | input | 1 | Watchdog time-out strobe |
| ext_rst_i | input | 1 | External reset strobe |
| ctx_save_i | input | 1 | Interrupt entry: save word to the shadow |
| ctx_restore_i | input | 1 | Interrupt return: restore writable bits |

## Verification
A CPU write and an ALU flag update can fall in the same cycle and compete for the writable bits. The bench raises both strobes in one cycle, with write data and ALU inputs that lead to different words, and expects the written value. It also puts a restore in the same cycle as a write, and a watchdog time-out in the same cycle as a watchdog-clear. In each case the expected word follows the priority given by the requirements.

// File: rtl/stat_pkg.sv
// Shared types and bit positions of the status word.
// Assumes an 8-bit word with the layout listed in the brief.
package stat_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_CMP = 2'd2,
        OP_ROT = 2'd3
    } alu_op_e;

    localparam int WORD_W = 8;
    localparam int BIT_C  = 0;
    localparam int BIT_DC = 1;
    localparam int BIT_Z  = 2;
    localparam int BIT_P  = 3;
    localparam int BIT_T  = 4;
    localparam logic [WORD_W-1:0] WR_MASK = 8'hE7;
endpackage

// File: rtl/stat_flag_eval.sv
// Turns the raw ALU carry, borrow and result inputs into new flag values
// and per-flag update enables. Purely combinational.
// Assumes the inputs are only meaningful while vld_i is high.
module stat_flag_eval
    import stat_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic             vld_i,
    input  alu_op_e          op_i,
    input  logic [RES_W-1:0] res_i,
    input  logic             cy_i,
    input  logic             hc_i,
    output logic             upd_c_o,
    output logic             upd_dc_o,
    output logic             upd_z_o,
    output logic             c_o,
    output logic             dc_o,
    output logic             z_o
);
    logic is_sub;

    // Classify the operation and build flag values and enables.
    always_comb begin
        is_sub   = (op_i == OP_SUB) || (op_i == OP_CMP);
        upd_c_o  = vld_i;
        upd_dc_o = vld_i && (op_i != OP_ROT);
        upd_z_o  = vld_i && (op_i != OP_ROT);
        c_o      = is_sub ? ~cy_i : cy_i;
        dc_o     = is_sub ? ~hc_i : hc_i;
        z_o      = (res_i == '0);
    end
endmodule

// File: rtl/stat_cause_bits.sv
// Holds the time-out (T) and power-down (P) cause bits.
// Assumes sleep and watchdog-clear are not raised in the same cycle.
// A time-out always decides T.
module stat_cause_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    input  logic wdt_clr_i,
    input  logic wdt_to_i,
    output logic t_o,
    output logic p_o
);
    // Cause-bit update from the event strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_o <= 1'b1;
            p_o <= 1'b1;
        end else begin
            if (wdt_to_i)
                t_o <= 1'b0;
            else if (sleep_i || wdt_clr_i)
                t_o <= 1'b1;
            if (wdt_clr_i)
                p_o <= 1'b1;
            else if (sleep_i)
                p_o <= 1'b0;
        end
    end

    p_sleep_clears_p_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && !wdt_clr_i) |=> !p_o);
    p_timeout_clears_t_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_to_i |=> !t_o);
    p_timeout_keeps_p_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_to_i && !sleep_i && !wdt_clr_i) |=> $stable(p_o));
    p_clear_sets_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_clr_i && !wdt_to_i) |=> (t_o && p_o));
    p_quiet_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && !wdt_clr_i && !wdt_to_i) |=> ($stable(t_o) && $stable(p_o)));
endmodule

// File: rtl/stat_ctx_shadow.sv
// Shadow copy of the status word for interrupt context.
// Assumes a single level of nesting: a new save overwrites the old copy.
module stat_ctx_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         save_i,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] shadow_o
);
    // Capture the live word on a save strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_o <= '0;
        else if (save_i)
            shadow_o <= word_i;
    end

    p_save_captures_r11: assert property (@(posedge clk) disable iff (!rst_n)
        save_i |=> (shadow_o == $past(word_i)));
endmodule

// File: rtl/alu_status_reg.sv
// Status word of the core: ALU flags, reset-cause bits and page selects.
// Priority for the writable bits is: external reset, then restore, then
// CPU write, then ALU update. Reset is synchronous and active low.
module alu_status_reg
    import stat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en_i,
    input  logic [7:0]  wr_data_i,
    output logic [7:0]  rd_data_o,
    input  logic        alu_vld_i,
    input  logic [1:0]  alu_op_i,
    input  logic [7:0]  alu_res_i,
    input  logic        alu_cy_i,
    input  logic        alu_hc_i,
    output logic        carry_o,
    input  logic        sleep_i,
    input  logic        wdt_clr_i,
    input  logic        wdt_to_i,
    input  logic        ext_rst_i,
    input  logic        ctx_save_i,
    input  logic        ctx_restore_i
);
    logic       upd_c, upd_dc, upd_z, f_c, f_dc, f_z;
    logic       t_q, p_q;
    logic [7:0] wr_q, wr_d, shadow;
    alu_op_e    op;

    assign op = alu_op_e'(alu_op_i);

    stat_flag_eval #(.RES_W(WORD_W)) u_eval (
        .vld_i(alu_vld_i), .op_i(op), .res_i(alu_res_i),
        .cy_i(alu_cy_i), .hc_i(alu_hc_i),
        .upd_c_o(upd_c), .upd_dc_o(upd_dc), .upd_z_o(upd_z),
        .c_o(f_c), .dc_o(f_dc), .z_o(f_z)
    );

    stat_cause_bits u_cause (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .wdt_clr_i(wdt_clr_i),
        .wdt_to_i(wdt_to_i), .t_o(t_q), .p_o(p_q)
    );

    stat_ctx_shadow #(.W(WORD_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .save_i(ctx_save_i),
        .word_i(rd_data_o), .shadow_o(shadow)
    );

    // Next value of the writable bits, in priority order.
    always_comb begin
        wr_d = wr_q;
        if (ext_rst_i)
            wr_d = '0;
        else if (ctx_restore_i)
            wr_d = shadow & WR_MASK;
        else if (wr_en_i)
            wr_d = wr_data_i & WR_MASK;
        else begin
            if (upd_c)  wr_d[BIT_C]  = f_c;
            if (upd_dc) wr_d[BIT_DC] = f_dc;
            if (upd_z)  wr_d[BIT_Z]  = f_z;
        end
    end

    // Register for the writable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_q <= '0;
        else
            wr_q <= wr_d;
    end

    // Merge the writable bits with the cause bits.
    always_comb begin
        rd_data_o        = wr_q;
        rd_data_o[BIT_T] = t_q;
        rd_data_o[BIT_P] = p_q;
    end

    assign carry_o = wr_q[BIT_C];

    p_ext_rst_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst_i |=> ((rd_data_o & WR_MASK) == 8'h00));
    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !ext_rst_i && !ctx_restore_i) |=>
        ((rd_data_o & WR_MASK) == ($past(wr_data_i) & WR_MASK)));
    p_rotate_keeps_z_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_vld_i && alu_op_i == 2'd3 && !wr_en_i && !ext_rst_i && !ctx_restore_i)
        |=> ($stable(rd_data_o[BIT_Z]) && $stable(rd_data_o[BIT_DC])
             && carry_o == $past(alu_cy_i)));
    p_add_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_vld_i && alu_op_i == 2'd0 && !wr_en_i && !ext_rst_i && !ctx_restore_i)
        |=> (carry_o == $past(alu_cy_i)));
    p_sub_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_vld_i && (alu_op_i == 2'd1 || alu_op_i == 2'd2) && !wr_en_i
         && !ext_rst_i && !ctx_restore_i) |=> (carry_o == !$past(alu_cy_i)));
endmodule

// File: tb/tb_alu_status_reg.sv
// Scoreboard bench: step() models the expected word and queues it, and
// the monitor compares each queued item at the following falling edge.
module tb_alu_status_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 0, alu_vld = 0, cy = 0, hc = 0;
    logic       slp = 0, clr = 0, to = 0, ext = 0, sav = 0, rst_ev = 0;
    logic [7:0] wdata = 0, res = 0, rd;
    logic [1:0] op = 0;
    logic       carry;

    typedef struct { logic [7:0] exp; string req; } item_t;
    item_t q[$];
    int total = 0, bad = 0;
    logic [7:0] m_word = 8'h00, m_shadow = 8'h00;
    bit done = 0;

    alu_status_reg dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wdata),
        .rd_data_o(rd), .alu_vld_i(alu_vld), .alu_op_i(op), .alu_res_i(res),
        .alu_cy_i(cy), .alu_hc_i(hc), .carry_o(carry), .sleep_i(slp),
        .wdt_clr_i(clr), .wdt_to_i(to), .ext_rst_i(ext),
        .ctx_save_i(sav), .ctx_restore_i(rst_ev)
    );

    always #4 clk = ~clk;

    // Monitor: pop and compare at each falling edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            total++;
            if (rd !== it.exp || carry !== it.exp[0]) begin
                bad++;
                $display("FAIL %s: word=%h carry=%b expected word=%h carry=%b",
                         it.req, rd, carry, it.exp, it.exp[0]);
            end
        end
    end

    // Driver: model the word from the requirements, clock once, queue it.
    task automatic step(input string req);
        logic [7:0] n;
        logic sub;
        n = m_word;
        if (!rst_n) begin
            n = 8'h18;
            m_shadow = 8'h00;
        end else begin
            if (sav) m_shadow = m_word;
            if (to) n[4] = 1'b0;
            else if (slp || clr) n[4] = 1'b1;
            if (clr) n[3] = 1'b1;
            else if (slp) n[3] = 1'b0;
            if (ext) n = n & 8'h18;
            else if (rst_ev) n = (n & 8'h18) | (m_shadow_prev() & 8'hE7);
            else if (wr_en) n = (n & 8'h18) | (wdata & 8'hE7);
            else if (alu_vld) begin
                sub = (op == 2'd1) || (op == 2'd2);
                if (op == 2'd3) n[0] = cy;
                else begin
                    n[0] = sub ? !cy : cy;
                    n[1] = sub ? !hc : hc;
                    n[2] = (res == 8'h00);
                end
            end
        end
        @(posedge clk);
        #1;
        m_word = n;
        q.push_back('{n, req});
        wr_en = 0; alu_vld = 0; slp = 0; clr = 0; to = 0;
        ext = 0; sav = 0; rst_ev = 0;
    endtask

    logic [7:0] shadow_before;
    function automatic logic [7:0] m_shadow_prev();
        return shadow_before;
    endfunction

    task automatic alu(input logic [1:0] o, input logic [7:0] r,
                       input logic c, input logic h, input string req);
        alu_vld = 1; op = o; res = r; cy = c; hc = h;
        shadow_before = m_shadow;
        step(req);
    endtask

    task automatic go(input string req);
        shadow_before = m_shadow;
        step(req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        go("R1 power-up value");
        rst_n = 1'b1;
        go("R1 hold after reset");
        wr_en = 1; wdata = 8'h00; go("R2 write zeros keeps T,P");
        wr_en = 1; wdata = 8'hFF; go("R2 write ones");
        wr_en = 1; wdata = 8'h40; go("R2 write page bits");
        alu(2'd0, 8'h00, 1'b1, 1'b1, "R3 add carry and zero");
        alu(2'd0, 8'h5A, 1'b0, 1'b0, "R3 add no carry");
        alu(2'd1, 8'h01, 1'b1, 1'b1, "R4 sub with borrow");
        alu(2'd1, 8'h00, 1'b0, 1'b0, "R4 sub no borrow zero");
        alu(2'd2, 8'h80, 1'b1, 1'b0, "R4 compare borrow");
        alu(2'd3, 8'h00, 1'b1, 1'b0, "R5 rotate shifts out one");
        alu(2'd3, 8'hFF, 1'b0, 1'b1, "R5 rotate keeps Z and DC");
        slp = 1; go("R6 sleep gives T=1 P=0");
        to = 1; go("R7 watchdog wake from sleep 0,0");
        clr = 1; go("R8 watchdog clear 1,1");
        to = 1; go("R7 time-out while awake 0,1");
        slp = 1; go("R6 sleep again");
        ext = 1; go("R9 external reset wake keeps 1,0");
        to = 1; clr = 1; go("R7 time-out beats clear for T");
        wr_en = 1; wdata = 8'hA5;
        alu_vld = 1; op = 2'd0; res = 8'h00; cy = 1'b0; hc = 1'b0;
        go("R10 write beats ALU");
        sav = 1; go("R11 save");
        wr_en = 1; wdata = 8'h02; go("R11 overwrite in handler");
        alu(2'd1, 8'h00, 1'b0, 1'b1, "R11 flags change in handler");
        slp = 1; go("R11 cause bits move in handler");
        rst_ev = 1; wr_en = 1; wdata = 8'hFF; go("R11 restore beats write");
        ext = 1; wr_en = 1; wdata = 8'hFF; go("R9 external reset beats write");
        go("R9 idle after reset strobe");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog for a hung run.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run did not finish, expected end");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule